// File: doc/BRIEF.md
# In-Order Instruction Queue with Three-Way Dispatch

This block buffers fetched instructions between the fetch stage and three issue queues. Up to four instructions enter per cycle as one group. Up to three leave per cycle, oldest first. The queue holds twelve entries and keeps them in a shift register, so the oldest entry always sits in position 0.

Each entry carries a two-bit class tag. The tag names its destination: the floating-point, vector or general-purpose issue queue, or no issue queue at all. An entry may leave only if three things hold. Its destination has room in this cycle. It is among the three oldest entries. Every older entry leaves in the same cycle. Every departing instruction also needs a free completion-queue slot, including an instruction of the "no issue queue" class.

Dispatch valids are combinational. They are driven from the head entries and from the current credit inputs. The entries flagged valid are removed at the next rising clock edge.

Top module: `iq_dispatch`

## Requirements
- R1: After reset the queue is empty, `disp_valid` is all zero, and `fetch_stall` is low while `fetch_cnt` is 0.
- R2: A fetch group of `fetch_cnt` (0 to 4) instructions is either taken whole or not at all. It is taken when `fetch_cnt` does not exceed the free entries at the start of the cycle (12 minus occupancy, ignoring same-cycle dispatch). `fetch_stall` is high exactly when it does exceed them. A stalled group leaves the queue unchanged.
- R3: Occupancy never exceeds 12. A queue holding 12 entries stalls any non-empty group.
- R4: Dispatch slot k carries the k-th oldest entry. Its payload is on `disp_instr[k*32 +: 32]` and its tag is on `disp_cls[2k +: 2]`. The valid bits always form a contiguous run starting at slot 0.
- R5: At most three instructions dispatch per cycle, and never more than `cq_free`.
- R6: Per cycle, the floating-point class dispatches at most min(1, `fp_credit`), the vector class at most min(2, `vec_credit`), and the general-purpose class at most min(3, `gp_credit`). A class whose ready input is low dispatches none.
- R7: Dispatch is strictly in order. When an entry cannot dispatch, no younger entry dispatches in that cycle.
- R8: Class 0 entries need only a completion-queue slot. They dispatch even when every issue queue is not ready.
- R9: A high `flush` empties the queue at the next edge and discards the fetch group of that cycle. During the flush cycle `disp_valid` is all zero.
- R10: The class encodings are 0 = none, 1 = floating-point, 2 = vector, and 3 = general-purpose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue, drop this cycle's fetch group |
| fetch_cnt | input | 3 | Number of instructions in the fetch group (0..4) |
| fetch_instr | input | 128 | Fetch payloads; slot k at [k*32 +: 32], slot 0 oldest |
| fetch_cls | input | 8 | Fetch class tags; slot k at [2k +: 2] |
| fetch_stall | output | 1 | Fetch group does not fit and is not taken |
| fp_rdy | input | 1 | Floating-point issue queue accepting |
| fp_credit | input | 2 | Floating-point issue queue free slots |
| vec_rdy | input | 1 | Vector issue queue accepting |
| vec_credit | input | 2 | Vector issue queue free slots |
| gp_rdy | input | 1 | General-purpose issue queue accepting |
| gp_credit | input | 2 | General-purpose issue queue free slots |
| cq_free | input | 4 | Free completion-queue slots |
| disp_valid | output | 3 | Dispatch valid per slot, slot 0 oldest |
| disp_instr | output | 96 | Dispatch payloads, slot k at [k*32 +: 32] |
| disp_cls | output | 6 | Dispatch class tags, slot k at [2k +: 2] |

## Verification
`disp_valid`, `disp_instr`, `disp_cls` and `fetch_stall` respond in the same cycle as the credit, completion-slot and fetch-count inputs. The bench therefore drives inputs on the falling edge and compares against a reference model a quarter period later, before the next rising edge. Queue contents change only at the rising edge. The reference model is updated after that edge, and the effect of each accepted group, dispatch or flush first appears in the following cycle's comparison. Directed sequences cover the following cases:
- filling to twelve entries, then offering a further group
- a head of floating-point entries against a wide credit
- vector-only and class-0 heads
- a blocked middle entry
- a flush that coincides with a fetch group

Seeded random cycles then cover the mixed cases.

// File: rtl/iq_dispatch.sv
module iq_dispatch #(
  parameter int DEPTH   = 12,
  parameter int FETCH_W = 4,
  parameter int DISP_W  = 3,
  parameter int DATA_W  = 32,
  parameter int CRED_W  = 2,
  parameter int CQ_W    = 4,
  parameter int FP_MAX  = 1,
  parameter int VEC_MAX = 2,
  parameter int GP_MAX  = 3,
  localparam int FC_W   = $clog2(FETCH_W + 1),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [FC_W-1:0]           fetch_cnt,
  input  logic [FETCH_W*DATA_W-1:0] fetch_instr,
  input  logic [FETCH_W*2-1:0]      fetch_cls,
  output logic                      fetch_stall,
  input  logic                      fp_rdy,
  input  logic [CRED_W-1:0]         fp_credit,
  input  logic                      vec_rdy,
  input  logic [CRED_W-1:0]         vec_credit,
  input  logic                      gp_rdy,
  input  logic [CRED_W-1:0]         gp_credit,
  input  logic [CQ_W-1:0]           cq_free,
  output logic [DISP_W-1:0]         disp_valid,
  output logic [DISP_W*DATA_W-1:0]  disp_instr,
  output logic [DISP_W*2-1:0]       disp_cls
);

  localparam logic [1:0] C_NONE = 2'd0;
  localparam logic [1:0] C_FP   = 2'd1;
  localparam logic [1:0] C_VEC  = 2'd2;
  localparam logic [1:0] C_GP   = 2'd3;

  logic [DATA_W-1:0] q_d [DEPTH];
  logic [1:0]        q_c [DEPTH];
  logic [CNT_W-1:0]  level;
  int                n_pop;
  int                base;
  logic              wr;

  function automatic int cap(logic rdy, int cred, int lim);
    if (!rdy) return 0;
    return (cred < lim) ? cred : lim;
  endfunction

  always_comb begin
    int   nf, nv, ng;
    logic blk, ok;
    disp_valid = '0;
    n_pop = 0;
    nf = 0; nv = 0; ng = 0;
    blk = flush;
    for (int i = 0; i < DISP_W; i++) begin
      ok = !blk && (i < int'(level)) && (n_pop < int'(cq_free));
      case (q_c[i])
        C_NONE: ;
        C_FP:   ok = ok && (nf < cap(fp_rdy,  int'(fp_credit),  FP_MAX));
        C_VEC:  ok = ok && (nv < cap(vec_rdy, int'(vec_credit), VEC_MAX));
        C_GP:   ok = ok && (ng < cap(gp_rdy,  int'(gp_credit),  GP_MAX));
      endcase
      if (ok) begin
        disp_valid[i] = 1'b1;
        n_pop++;
        if (q_c[i] == C_FP)  nf++;
        if (q_c[i] == C_VEC) nv++;
        if (q_c[i] == C_GP)  ng++;
      end else begin
        blk = 1'b1;
      end
    end
  end

  assign fetch_stall = int'(fetch_cnt) > (DEPTH - int'(level));
  assign wr          = !flush && (fetch_cnt != '0) && !fetch_stall;
  assign base        = int'(level) - n_pop;

  for (genvar g = 0; g < DISP_W; g++) begin : g_out
    assign disp_instr[g*DATA_W +: DATA_W] = q_d[g];
    assign disp_cls[g*2 +: 2]             = q_c[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      for (int j = 0; j < DEPTH; j++) begin
        q_d[j] <= '0;
        q_c[j] <= C_NONE;
      end
    end else if (flush) begin
      level <= '0;
    end else begin
      for (int j = 0; j < DEPTH; j++) begin
        if (j + n_pop < int'(level)) begin
          q_d[j] <= q_d[j + n_pop];
          q_c[j] <= q_c[j + n_pop];
        end else if (wr && j >= base && (j - base) < int'(fetch_cnt)) begin
          q_d[j] <= fetch_instr[(j - base)*DATA_W +: DATA_W];
          q_c[j] <= fetch_cls[(j - base)*2 +: 2];
        end
      end
      level <= CNT_W'(base + (wr ? int'(fetch_cnt) : 0));
    end
  end

endmodule

// File: rtl/iq_dispatch_chk.sv
module iq_dispatch_chk #(
  parameter int DEPTH  = 12,
  parameter int DISP_W = 3,
  parameter int CNT_W  = 4,
  parameter int FC_W   = 3,
  parameter int CQ_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [FC_W-1:0]   fetch_cnt,
  input logic              fetch_stall,
  input logic              fp_rdy,
  input logic [CQ_W-1:0]   cq_free,
  input logic [DISP_W-1:0] disp_valid,
  input logic [DISP_W*2-1:0] disp_cls,
  input logic [CNT_W-1:0]  level
);

  int fp_n;
  always_comb begin
    fp_n = 0;
    for (int i = 0; i < DISP_W; i++)
      if (disp_valid[i] && disp_cls[i*2 +: 2] == 2'd1) fp_n++;
  end

  // R2
  empty_group_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_cnt == '0) |-> !fetch_stall);

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  // R4
  valid_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((disp_valid + 1'b1) & disp_valid) == '0);

  // R5
  cq_slot_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disp_valid) <= int'(cq_free));

  // R6
  fp_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_n <= 1 && (fp_rdy || fp_n == 0));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0) && (disp_valid == '0));

  // R9
  flush_no_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> disp_valid == '0);

endmodule

bind iq_dispatch iq_dispatch_chk #(
  .DEPTH(DEPTH), .DISP_W(DISP_W), .CNT_W(CNT_W), .FC_W(FC_W), .CQ_W(CQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_cnt(fetch_cnt),
  .fetch_stall(fetch_stall), .fp_rdy(fp_rdy), .cq_free(cq_free),
  .disp_valid(disp_valid), .disp_cls(disp_cls), .level(level)
);

// File: tb/tb_iq_dispatch.sv
module tb_iq_dispatch;
  localparam int P     = 10;
  localparam int DEPTH = 12;
  localparam int FW    = 4;
  localparam int DW    = 3;
  localparam int XW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [2:0] fetch_cnt = '0;
  logic [FW*XW-1:0] fetch_instr = '0;
  logic [FW*2-1:0] fetch_cls = '0;
  logic fetch_stall;
  logic fp_rdy = 1'b0, vec_rdy = 1'b0, gp_rdy = 1'b0;
  logic [1:0] fp_credit = '0, vec_credit = '0, gp_credit = '0;
  logic [3:0] cq_free = '0;
  logic [DW-1:0] disp_valid;
  logic [DW*XW-1:0] disp_instr;
  logic [DW*2-1:0] disp_cls;

  iq_dispatch dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_cnt(fetch_cnt),
    .fetch_instr(fetch_instr), .fetch_cls(fetch_cls), .fetch_stall(fetch_stall),
    .fp_rdy(fp_rdy), .fp_credit(fp_credit), .vec_rdy(vec_rdy), .vec_credit(vec_credit),
    .gp_rdy(gp_rdy), .gp_credit(gp_credit), .cq_free(cq_free),
    .disp_valid(disp_valid), .disp_instr(disp_instr), .disp_cls(disp_cls)
  );

  always #(P/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int m_cnt = 0;
  logic [XW-1:0] m_d [DEPTH];
  logic [1:0]    m_c [DEPTH];
  int unsigned nid = 1;
  bit done = 0;

  task automatic chk(bit ok, string req, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int cap(bit r, int c, int m);
    if (!r) return 0;
    return (c < m) ? c : m;
  endfunction

  task automatic step(int fc, bit fl, bit fr, int fcr, bit vr, int vcr,
                      bit gr, int gcr, int cq, logic [7:0] cls, string tag);
    int emask, n, nf, nv, ng, lim;
    bit blk, ok, est;
    @(negedge clk);
    fetch_cnt = 3'(fc); flush = fl; fetch_cls = cls;
    fp_rdy = fr; fp_credit = 2'(fcr); vec_rdy = vr; vec_credit = 2'(vcr);
    gp_rdy = gr; gp_credit = 2'(gcr); cq_free = 4'(cq);
    for (int k = 0; k < FW; k++) fetch_instr[k*XW +: XW] = nid + k;
    #(P/4);
    emask = 0; n = 0; nf = 0; nv = 0; ng = 0; blk = fl;
    for (int i = 0; i < DW; i++) begin
      ok = !blk && i < m_cnt && n < cq;
      if (ok) begin
        case (m_c[i])
          2'd1: ok = nf < cap(fr, fcr, 1);
          2'd2: ok = nv < cap(vr, vcr, 2);
          2'd3: ok = ng < cap(gr, gcr, 3);
          default: ok = 1;
        endcase
      end
      if (ok) begin
        emask |= (1 << i); n++;
        if (m_c[i] == 2'd1) nf++;
        if (m_c[i] == 2'd2) nv++;
        if (m_c[i] == 2'd3) ng++;
      end else blk = 1;
    end
    est = fc > DEPTH - m_cnt;
    // R4 R5 R6 R7 R8 R9: dispatch mask
    chk(disp_valid == DW'(emask), {tag, " disp_valid"}, disp_valid, emask);
    // R2 R3: stall
    chk(fetch_stall == est, {tag, " fetch_stall R2"}, fetch_stall, est);
    for (int i = 0; i < n; i++) begin
      chk(disp_instr[i*XW +: XW] == m_d[i], {tag, " payload order R4"},
          disp_instr[i*XW +: XW], m_d[i]);
      chk(disp_cls[i*2 +: 2] == m_c[i], {tag, " class R10"}, disp_cls[i*2 +: 2], m_c[i]);
    end
    @(posedge clk);
    if (fl) m_cnt = 0;
    else begin
      for (int j = 0; j + n < m_cnt; j++) begin
        m_d[j] = m_d[j+n]; m_c[j] = m_c[j+n];
      end
      m_cnt -= n;
      if (fc > 0 && !est) begin
        for (int k = 0; k < fc; k++) begin
          m_d[m_cnt] = nid + k; m_c[m_cnt] = cls[k*2 +: 2]; m_cnt++;
        end
      end
    end
    nid += FW;
    lim = 0;
  endtask

  initial begin
    #(P*200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #(P*2);
    // R1
    chk(disp_valid == '0, "R1 reset disp_valid", disp_valid, 0);
    chk(fetch_stall == 1'b0, "R1 reset fetch_stall", fetch_stall, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: empty queue, nothing issues even with all credit
    step(0, 0, 1, 3, 1, 3, 1, 3, 7, 8'h00, "R1");
    // R3: fill with blocked FP entries to capacity, then overflow group
    step(4, 0, 0, 3, 1, 3, 1, 3, 7, 8'h55, "R3 fill");
    step(4, 0, 0, 3, 1, 3, 1, 3, 7, 8'h55, "R3 fill");
    step(4, 0, 0, 3, 1, 3, 1, 3, 7, 8'h55, "R3 fill");
    step(1, 0, 0, 3, 1, 3, 1, 3, 7, 8'h55, "R3 full");
    // R6: FP head, only one per cycle despite wide credit
    step(0, 0, 1, 3, 1, 3, 1, 3, 7, 8'h00, "R6 fp");
    step(2, 0, 1, 0, 1, 3, 1, 3, 7, 8'hFF, "R6 fp zero credit");
    // R9: flush with a concurrent fetch group
    step(4, 1, 1, 3, 1, 3, 1, 3, 7, 8'hFF, "R9 flush");
    step(0, 0, 1, 3, 1, 3, 1, 3, 7, 8'h00, "R9 after flush");
    // R6: vector head, two per cycle
    step(4, 0, 1, 3, 1, 3, 1, 3, 7, 8'hAA, "R6 vec");
    step(0, 0, 1, 3, 1, 3, 1, 3, 7, 8'h00, "R6 vec");
    step(0, 0, 1, 3, 1, 3, 1, 3, 7, 8'h00, "R6 vec");
    // R8: class none with no issue queue ready
    step(4, 0, 0, 0, 0, 0, 0, 0, 7, 8'h00, "R8 none");
    step(0, 0, 0, 0, 0, 0, 0, 0, 7, 8'h00, "R8 none");
    // R5: completion slots limit
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h00, "R5 cq");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R5 cq zero");
    step(0, 1, 1, 3, 1, 3, 1, 3, 7, 8'h00, "R9 flush2");
    // R7: gp, fp(blocked), gp
    step(3, 0, 0, 3, 1, 3, 1, 3, 7, 8'h37, "R7 fill");
    step(0, 0, 0, 3, 1, 3, 1, 3, 7, 8'h00, "R7 block");
    step(0, 0, 1, 1, 1, 3, 1, 3, 7, 8'h00, "R7 unblock");
    // GP credit limit
    step(3, 0, 1, 3, 1, 3, 1, 3, 7, 8'h3F, "R6 gp fill");
    step(0, 0, 1, 3, 1, 3, 1, 2, 7, 8'h00, "R6 gp credit");
    step(0, 0, 1, 3, 1, 3, 1, 3, 7, 8'h00, "R6 gp");
    // random mix
    for (int c = 0; c < 4000; c++) begin
      step($urandom_range(0, 4), ($urandom_range(0, 49) == 0),
           ($urandom_range(0, 3) != 0), $urandom_range(0, 3),
           ($urandom_range(0, 3) != 0), $urandom_range(0, 3),
           ($urandom_range(0, 3) != 0), $urandom_range(0, 3),
           $urandom_range(0, 5), 8'($urandom), "R4 R5 R6 R7 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule